// File: doc/BRIEF.md
# Shared Timer Tick Prescaler

This block generates count-enable ticks for two timer channels from one shared, free-running clock divider. Each channel has its own 3-bit select code. A channel can be held still, tick on every system clock, tick from one of four divider taps (divide by 8, 64, 256 or 1024), or tick on edges of its own external pin. Every output is a one-cycle pulse in the system clock domain. It is never a derived clock. The counters that consume the ticks sit outside this block.

The divider counts on every clock whatever either channel has selected. A synchronous clear input restarts it, and because the divider is shared, that restart changes the tick phase of every channel running from a tap. The external pin path captures the pin on the falling clock edge and then on the rising edge. A history register then compares the synchronized sample with the one before it. The result is a registered pulse, so a pin edge reaches the consuming counter 2.5 to 3.5 system clocks later.

Top module: `dual_tick_prescaler`

## Requirements
- R1: The active-low asynchronous reset clears the divider, the pin samplers and the edge history. Just after release no tick is active. A divide-by-8 channel first ticks in the cycle after the 7th rising edge that follows release. A pin held high through reset on a rising-edge channel produces exactly one tick after release.
- R2: Select code 0 produces no ticks.
- R3: Select code 1 produces a tick in every cycle.
- R4: Select codes 2, 3, 4 and 5 tick whenever the low 3, 6, 8 or 10 bits of the shared divider are all ones. That gives one tick every 8, 64, 256 or 1024 cycles. Changing a select code never restarts the divider.
- R5: The two channels decode their select codes independently but read the same divider. A tap channel's phase therefore does not depend on the other channel.
- R6: A clear input sampled high sets the divider to zero at that edge for both channels. A channel with divisor N then first ticks in the cycle after the (N-1)th following edge.
- R7: Select code 7 gives one tick for each rising edge of the synchronized pin. A pin change made just after rising edge k produces a tick in the cycle between edges k+2 and k+3.
- R8: Select code 6 gives one tick for each falling edge of the synchronized pin, with the same timing as R7.
- R9: Pin activity has no effect on a channel whose select code is 0 to 5. A tick from the pin path lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_clr | input | 1 | Synchronous restart of the shared divider |
| ch_sel | input | NUM_CH x 3 | Per-channel select code (0 stop, 1 every cycle, 2-5 taps, 6 pin fall, 7 pin rise) |
| ext_pin | input | NUM_CH | Per-channel external count pin |
| cnt_en | output | NUM_CH | Per-channel one-cycle count-enable tick |

## Verification
Tap and every-cycle ticks are combinational from the divider register. They are due in the same cycle in which the divider value computed from the edges since the last clear or reset matches. Pin ticks are due in the cycle after the second rising edge following the pin change. The driver changes pins 1 ns after a rising edge and queues the cycle index at which the tick is due. A monitor samples on every falling edge, compares both channels against the expected value for their select code, and pops the queue entry when it is due, so an early, late or missing tick shows up as a mismatch.

// File: rtl/tick_presc_pkg.sv
package tick_presc_pkg;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 4;

    typedef enum logic [2:0] {
        SRC_OFF,
        SRC_SYS,
        SRC_TAP,
        SRC_PIN_FALL,
        SRC_PIN_RISE
    } src_e;

    // Map a select code to its tick source.
    function automatic src_e decode_sel(input logic [SEL_W-1:0] code);
        src_e res;
        unique case (code)
            3'd0:                      res = SRC_OFF;
            3'd1:                      res = SRC_SYS;
            3'd2, 3'd3, 3'd4, 3'd5:    res = SRC_TAP;
            3'd6:                      res = SRC_PIN_FALL;
            default:                   res = SRC_PIN_RISE;
        endcase
        return res;
    endfunction

    // Log2 of the divisor of each divider tap: 8, 64, 256, 1024.
    function automatic int tap_log2(input int idx);
        int res;
        case (idx)
            0:       res = 3;
            1:       res = 6;
            2:       res = 8;
            default: res = 10;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/presc_divider.sv
module presc_divider
    import tick_presc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                presc_clr,
    output logic [NUM_TAPS-1:0] tap_pls
);

    localparam int TOP_LG = tap_log2(NUM_TAPS - 1);

    logic [CNT_W-1:0] div_q;

    // Free-running divider; only reset and the clear input touch it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (presc_clr) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
        localparam int LG = tap_log2(t);
        assign tap_pls[t] = &div_q[LG-1:0];
        if (t > 0) begin : g_nest
            AST_TAP_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
                tap_pls[t] |-> tap_pls[t-1]); // R4
        end
    end

    initial begin
        if (CNT_W < TOP_LG) $error("divider narrower than largest tap");
    end

    AST_DIV_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        !presc_clr |=> div_q == $past(div_q) + 1'b1); // R4
    AST_DIV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |=> div_q == '0); // R6

endmodule

// File: rtl/pin_edge_sync.sv
module pin_edge_sync
    import tick_presc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  src_e mode,
    output logic ext_pls
);

    logic fall_smp_q;
    logic sync_q;
    logic hist_q;
    logic rise_seen;
    logic fall_seen;

    // First stage: holds the pin value seen at the end of the high phase.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_smp_q <= 1'b0;
        else        fall_smp_q <= pin;
    end

    // Second stage and edge history.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= fall_smp_q;
            hist_q <= sync_q;
        end
    end

    assign rise_seen = sync_q & ~hist_q;
    assign fall_seen = ~sync_q & hist_q;

    // Registered edge pulse, filtered by the selected polarity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_pls <= 1'b0;
        end else begin
            unique case (mode)
                SRC_PIN_RISE: ext_pls <= rise_seen;
                SRC_PIN_FALL: ext_pls <= fall_seen;
                default:      ext_pls <= 1'b0;
            endcase
        end
    end

    AST_PIN_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pls && $stable(mode) |=> !ext_pls); // R9
    AST_PIN_PULSE_HAS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pls |-> $past(sync_q) != $past(hist_q)); // R7
    AST_PIN_PULSE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_pls |-> ($past(mode) == SRC_PIN_RISE || $past(mode) == SRC_PIN_FALL)); // R9

endmodule

// File: rtl/dual_tick_prescaler.sv
module dual_tick_prescaler
    import tick_presc_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         presc_clr,
    input  logic [NUM_CH-1:0][SEL_W-1:0] ch_sel,
    input  logic [NUM_CH-1:0]            ext_pin,
    output logic [NUM_CH-1:0]            cnt_en
);

    logic [NUM_TAPS-1:0] tap_pls;

    presc_divider #(.CNT_W(CNT_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_clr (presc_clr),
        .tap_pls   (tap_pls)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        src_e       mode;
        logic [1:0] tap_idx;
        logic       ext_pls;

        assign mode    = decode_sel(ch_sel[c]);
        assign tap_idx = 2'(ch_sel[c] - 3'd2);

        pin_edge_sync u_pin (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (ext_pin[c]),
            .mode    (mode),
            .ext_pls (ext_pls)
        );

        always_comb begin
            unique case (mode)
                SRC_OFF:      cnt_en[c] = 1'b0;
                SRC_SYS:      cnt_en[c] = 1'b1;
                SRC_TAP:      cnt_en[c] = tap_pls[tap_idx];
                SRC_PIN_FALL,
                SRC_PIN_RISE: cnt_en[c] = ext_pls;
                default:      cnt_en[c] = 1'b0;
            endcase
        end

        AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ch_sel[c] == 3'd0 |-> !cnt_en[c]); // R2
        AST_SYS_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
            ch_sel[c] == 3'd1 |-> cnt_en[c]); // R3
    end

    if (NUM_CH > 1) begin : g_shared
        AST_SHARED_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_sel[0] == ch_sel[1] && ch_sel[0] >= 3'd2 && ch_sel[0] <= 3'd5)
            |-> cnt_en[0] == cnt_en[1]); // R5
    end

endmodule

// File: tb/dual_tick_prescaler_tb.sv
`timescale 1ns/1ps
module dual_tick_prescaler_tb;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            presc_clr = 1'b0;
    logic [1:0][2:0] ch_sel;
    logic [1:0]      ext_pin;
    logic [1:0]      cnt_en;

    int  cyc = 0;
    int  kc = 0;
    int  n_chk = 0;
    int  n_err = 0;
    int  q0[$];
    int  q1[$];
    bit  done = 1'b0;
    bit  noise = 1'b0;

    always #4 clk = ~clk;

    dual_tick_prescaler u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .presc_clr (presc_clr),
        .ch_sel    (ch_sel),
        .ext_pin   (ext_pin),
        .cnt_en    (cnt_en)
    );

    // Edge index since reset release and the edge of the latest clear.
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 0;
            kc  <= 0;
        end else begin
            cyc <= cyc + 1;
            if (presc_clr) kc <= cyc + 1;
        end
    end

    task automatic chk(input string tag, input int ch, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s ch%0d cyc %0d: actual %b expected %b", tag, ch, cyc, act, exp);
        end
    endtask

    // Monitor: pops due pin ticks and compares every channel each cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int ch = 0; ch < 2; ch++) begin
                logic  exp;
                string tag;
                int    sel;
                int    n;
                sel = int'(ch_sel[ch]);
                exp = 1'b0;
                tag = "R2";
                if (sel == 1) begin
                    exp = 1'b1;
                    tag = "R3";
                end else if (sel >= 2 && sel <= 5) begin
                    n   = (sel == 2) ? 8 : (sel == 3) ? 64 : (sel == 4) ? 256 : 1024;
                    exp = ((cyc - kc) % n) == n - 1;
                    tag = (kc > 0) ? "R6" : ((ch == 1) ? "R5" : "R4");
                end else if (sel >= 6) begin
                    tag = (sel == 7) ? "R7" : "R8";
                    if (ch == 0) begin
                        while (q0.size() > 0 && q0[0] < cyc) begin
                            chk(tag, ch, 1'b0, 1'b1);
                            void'(q0.pop_front());
                        end
                        exp = (q0.size() > 0 && q0[0] == cyc);
                        if (exp) void'(q0.pop_front());
                    end else begin
                        while (q1.size() > 0 && q1[0] < cyc) begin
                            chk(tag, ch, 1'b0, 1'b1);
                            void'(q1.pop_front());
                        end
                        exp = (q1.size() > 0 && q1[0] == cyc);
                        if (exp) void'(q1.pop_front());
                    end
                end
                if (noise && sel <= 5) tag = "R9";
                chk(tag, ch, cnt_en[ch], exp);
            end
        end
    end

    task automatic set_sel(input logic [2:0] a, input logic [2:0] b);
        @(posedge clk); #1;
        ch_sel[0] = a;
        ch_sel[1] = b;
    endtask

    // Driver: change a pin after an edge and queue any tick it must cause.
    task automatic pin_set(input int ch, input logic v);
        logic old;
        @(posedge clk); #1;
        old = ext_pin[ch];
        ext_pin[ch] = v;
        if (v != old) begin
            if ((ch_sel[ch] == 3'd7 && v) || (ch_sel[ch] == 3'd6 && !v)) begin
                if (ch == 0) q0.push_back(cyc + 2);
                else         q1.push_back(cyc + 2);
            end
        end
    endtask

    task automatic pulse_clr();
        @(posedge clk); #1 presc_clr = 1'b1;
        @(posedge clk); #1 presc_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        ch_sel[0] = 3'd2;
        ch_sel[1] = 3'd7;
        ext_pin   = 2'b10;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        q1.push_back(2);                       // R1: pin high through reset
        @(negedge clk);
        chk("R1", 0, cnt_en[0], 1'b0);
        chk("R1", 1, cnt_en[1], 1'b0);
        repeat (7) @(negedge clk);
        chk("R1", 0, cnt_en[0], 1'b1);         // first divide-by-8 tick
        repeat (30) @(posedge clk);

        set_sel(3'd3, 3'd1);                    // R3, R4
        repeat (200) @(posedge clk);

        set_sel(3'd0, 3'd4);                    // R2, R5, R9
        noise = 1'b1;
        for (int i = 0; i < 10; i++) pin_set(0, (i % 2) == 0);
        pin_set(1, 1'b0);
        pin_set(1, 1'b1);
        pin_set(0, 1'b0);
        repeat (6) @(posedge clk);
        noise = 1'b0;
        repeat (300) @(posedge clk);

        set_sel(3'd5, 3'd2);                    // R6
        pulse_clr();
        repeat (1100) @(posedge clk);

        set_sel(3'd7, 3'd6);                    // R7, R8
        repeat (4) @(posedge clk);
        pin_set(0, 1'b1);
        repeat (4) @(posedge clk);
        pin_set(1, 1'b0);
        pin_set(0, 1'b0);
        repeat (3) @(posedge clk);
        for (int i = 0; i < 6; i++) begin
            pin_set(0, (i % 2) == 0);
            pin_set(1, (i % 2) == 0);
        end
        repeat (8) @(posedge clk);
        chk("R7", 0, q0.size() == 0, 1'b1);
        chk("R8", 1, q1.size() == 0, 1'b1);

        set_sel(3'd3, 3'd3);                    // R6 mid-period clear
        repeat (20) @(posedge clk);
        pulse_clr();
        repeat (150) @(posedge clk);

        finish_run();
    end

endmodule